// File: doc/BRIEF.md
# Partitioned Entry Bus Sequencer

This block moves 80-bit table entries between a narrow host bus and a wide entry register. Each entry is split at a configurable bit position. The low part is the key (CAM) portion and the high part is the associated-data (RAM) portion. The bus is either 16 or 32 bits wide.

When an operation code arrives, the sequencer works out two things from the opcode and the held configuration:
- which portions travel on the write side, and how many bus words that takes;
- which portions travel on the read side, and how many bus words that takes.

It then steps through those words. Write words are packed into the entry register, and read words are unpacked from a wide read-entry input onto the data-out bus. The two portions never share a bus word, so an odd-sized remainder of the key portion costs a word of its own.

There is no backpressure on either side. Write words are taken whenever the write strobe is high while the sequencer expects data. Read words leave one per cycle, each flagged by a one-cycle valid pulse, and a word that nobody takes is replaced by the next one. A done pulse closes every operation, including operations that transfer nothing.

Top module: `entry_bus_seq`

## Requirements
- R1: After a synchronous active-high reset, the block is in the following state:
  - busy, done and doutValid are 0;
  - entryOut and doutData are all zeros;
  - the held configuration is 32-bit bus with no RAM portion.
- R2: A configuration load (cfgLoad with cfgWideIn, 1 = 32-bit bus, and cfgPartIn) takes effect only on a clock edge where the sequencer is idle. A load presented while busy is dropped, and later operations keep using the previous configuration.
- R3: cfgPartIn selects the RAM portion, and the CAM portion is the rest of the entry:

  | cfgPartIn | RAM portion | CAM portion |
  |---|---|---|
  | 0 | none | [79:0] |
  | 1 | [79:64] | [63:0] |
  | 2 | [79:48] | [47:0] |
  | 3 | [79:32] | [31:0] |

  On the 32-bit bus, the CAM portion is carried first in ascending 32-bit pieces, then the RAM portion in ascending 32-bit pieces. A piece never crosses the CAM/RAM boundary. For example, partition 2 uses [31:0], [47:32], [79:48].
- R4: On the 16-bit bus, each transferred portion is carried in ascending 16-bit slices. The slices sit at bits 0, 16, 32, 48 and 64, and each belongs to CAM or RAM according to the partition.
- R5: A 16-bit slice uses bus bits [15:0]. On data-out, bits [31:16] are driven to zero. On data-in, bits [31:16] of a 16-bit slice are ignored.
- R6: Opcodes and the portions they write from data-in into entryOut:
  - 0 insert: CAM and RAM.
  - 1 search: CAM only.
  - 2 associative search: CAM only.
  - 3 learn: CAM and RAM.
  - 4 delete: CAM only.
  - 5 and 6, the two queue reads: nothing.
  - 7: nothing.

  Bits that are not written keep their value.
- R7: The search opcodes (1 and 2) read back the RAM portion of rdEntry. The queue reads (5 and 6) read back both portions. All other opcodes produce no output words.
- R8: An operation starts on the edge where opValid is sampled while the sequencer is idle. Write words are captured on later edges where dinWrite is high. Take the last write capture as edge Ew, or the opcode edge when nothing is written. Then the n read words appear after edges Ew+1 … Ew+n, one per cycle, each with doutValid high for that cycle.
- R9: done is high for exactly one cycle after edge Ew+n (with n = 0 it follows Ew directly). This also covers an operation whose selected portion is empty, such as a RAM read with no RAM portion.
- R10: While the sequencer is busy, opValid is ignored. While it is idle, dinWrite has no effect on entryOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgLoad | input | 1 | Load strobe for the bus-width and partition settings |
| cfgWideIn | input | 1 | Bus width to load: 1 = 32-bit, 0 = 16-bit |
| cfgPartIn | input | 2 | Partition code to load (see R3) |
| opValid | input | 1 | Opcode strobe |
| opCode | input | 3 | Operation code (see R6, R7) |
| dinWrite | input | 1 | Write strobe for dinData |
| dinData | input | 32 | Host write word |
| rdEntry | input | 80 | Wide entry that the read phase unpacks |
| entryOut | output | 80 | Entry register assembled from write words |
| doutData | output | 32 | Host read word |
| doutValid | output | 1 | One-cycle pulse per new read word |
| done | output | 1 | One-cycle end-of-operation pulse |
| busy | output | 1 | High while an operation is in progress |

## Verification
Every result has a fixed position in time relative to the edges that trigger it:
- a read word is due one cycle after its emitting edge, with the first word on the edge after the last write capture;
- done arrives together with the last read word, or one cycle after the final capture when nothing is read;
- entryOut is final once done is seen.

The bench counts cycles from the opcode edge. For each read word it queues the value and the exact cycle at which it is due, and it queues the due cycle for each done. A monitor sampling on the falling edge compares every valid word and every done against the head of these queues, so an early, late, missing or extra pulse fails as surely as a wrong value. The bench inserts gaps between write words and presents an opcode and a configuration load while busy, and these shift or leave unchanged the predicted cycles exactly as the requirements say.

// File: rtl/entry_bus_seq_pkg.sv
package entry_bus_seq_pkg;

  parameter int ENTRY_W    = 80;
  parameter int BUS_W      = 32;
  parameter int HALF_W     = 16;
  parameter int PART_STEP  = 16;
  parameter int MAX_SLICES = ENTRY_W / HALF_W;
  parameter int CNT_W      = $clog2(MAX_SLICES + 1);
  parameter int LO_W       = $clog2(ENTRY_W);

  typedef enum logic [2:0] {
    OP_INSERT   = 3'd0,
    OP_SEARCH   = 3'd1,
    OP_SEARCH_A = 3'd2,
    OP_LEARN    = 3'd3,
    OP_DELETE   = 3'd4,
    OP_RD_LQ    = 3'd5,
    OP_RD_AQ    = 3'd6,
    OP_NOP      = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ
  } state_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic            load;
    logic            emit;
    logic [LO_W-1:0] lo;
    logic            wide;
  } strobe_t;

  // Width of the key portion for a partition code
  function automatic int camBits(logic [1:0] part);
    return ENTRY_W - PART_STEP * int'(part);
  endfunction

  // Number of bus words needed for a portion of the given width
  function automatic logic [CNT_W-1:0] pieceCount(int bits, logic wide);
    int w;
    w = wide ? BUS_W : HALF_W;
    return CNT_W'((bits + w - 1) / w);
  endfunction

  function automatic logic writesCam(opcode_e op);
    return (op == OP_INSERT) || (op == OP_SEARCH) || (op == OP_SEARCH_A) ||
           (op == OP_LEARN) || (op == OP_DELETE);
  endfunction

  function automatic logic writesRam(opcode_e op);
    return (op == OP_INSERT) || (op == OP_LEARN);
  endfunction

  function automatic logic readsCam(opcode_e op);
    return (op == OP_RD_LQ) || (op == OP_RD_AQ);
  endfunction

  function automatic logic readsRam(opcode_e op);
    return (op == OP_SEARCH) || (op == OP_SEARCH_A) ||
           (op == OP_RD_LQ) || (op == OP_RD_AQ);
  endfunction

  function automatic logic [CNT_W-1:0] phaseTotal(logic inclCam, logic inclRam,
                                                  logic [CNT_W-1:0] camCnt,
                                                  logic [CNT_W-1:0] ramCnt);
    return CNT_W'((inclCam ? camCnt : '0) + (inclRam ? ramCnt : '0));
  endfunction

endpackage

// File: rtl/entry_bus_seq_ctrl.sv
module entry_bus_seq_ctrl
  import entry_bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgLoad,
  input  logic       cfgWideIn,
  input  logic [1:0] cfgPartIn,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       dinWrite,
  output strobe_t    strb,
  output logic       done,
  output logic       busy
);

  state_e           state;
  opcode_e          opReg;
  logic [CNT_W-1:0] idx;
  logic             wideCfg;
  logic [1:0]       partCfg;

  int               camW;
  int               sBase;
  int               sEnd;
  int               sIdx;
  int               sLo;
  logic [CNT_W-1:0] camCnt;
  logic [CNT_W-1:0] ramCnt;
  logic [CNT_W-1:0] wrTot;
  logic [CNT_W-1:0] rdTot;
  logic [CNT_W-1:0] startWr;
  logic [CNT_W-1:0] startRd;
  logic             inclCam;
  logic             lastIdxWr;
  logic             lastIdxRd;
  opcode_e          newOp;

  always_comb begin
    newOp   = opcode_e'(opCode);
    camW    = camBits(partCfg);
    camCnt  = pieceCount(camW, wideCfg);
    ramCnt  = pieceCount(ENTRY_W - camW, wideCfg);
    wrTot   = phaseTotal(writesCam(opReg), writesRam(opReg), camCnt, ramCnt);
    rdTot   = phaseTotal(readsCam(opReg), readsRam(opReg), camCnt, ramCnt);
    startWr = phaseTotal(writesCam(newOp), writesRam(newOp), camCnt, ramCnt);
    startRd = phaseTotal(readsCam(newOp), readsRam(newOp), camCnt, ramCnt);

    lastIdxWr = (idx == wrTot - CNT_W'(1));
    lastIdxRd = (idx == rdTot - CNT_W'(1));

    // Slice position: key pieces first, then data pieces
    inclCam = (state == ST_WRITE) ? writesCam(opReg) : readsCam(opReg);
    if (inclCam && (idx < camCnt)) begin
      sBase = 0;
      sEnd  = camW;
      sIdx  = int'(idx);
    end else begin
      sBase = camW;
      sEnd  = ENTRY_W;
      sIdx  = int'(idx) - (inclCam ? int'(camCnt) : 0);
    end
    sLo = sBase + sIdx * (wideCfg ? BUS_W : HALF_W);

    strb.load = (state == ST_WRITE) && dinWrite;
    strb.emit = (state == ST_READ);
    strb.lo   = LO_W'(sLo);
    strb.wide = wideCfg && ((sEnd - sLo) >= BUS_W);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      opReg   <= OP_NOP;
      idx     <= '0;
      wideCfg <= 1'b1;
      partCfg <= 2'd0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cfgLoad) begin
            wideCfg <= cfgWideIn;
            partCfg <= cfgPartIn;
          end
          if (opValid) begin
            opReg <= newOp;
            idx   <= '0;
            if (startWr != '0)      state <= ST_WRITE;
            else if (startRd != '0) state <= ST_READ;
            else                    done  <= 1'b1;
          end
        end
        ST_WRITE: begin
          if (dinWrite) begin
            if (lastIdxWr) begin
              idx <= '0;
              if (rdTot != '0) begin
                state <= ST_READ;
              end else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end else begin
              idx <= idx + CNT_W'(1);
            end
          end
        end
        ST_READ: begin
          if (lastIdxRd) begin
            idx   <= '0;
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(wideCfg) && $stable(partCfg))); // R2

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (int'(idx) < MAX_SLICES)); // R3

  AST_SLICE_FITS: assert property (@(posedge clk) disable iff (rst)
    (strb.load || strb.emit) |->
      (int'(strb.lo) + (strb.wide ? BUS_W : HALF_W) <= ENTRY_W)); // R3

  AST_NARROW_SLICE: assert property (@(posedge clk) disable iff (rst)
    ((strb.load || strb.emit) && !wideCfg) |-> !strb.wide); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE)); // R9

endmodule

// File: rtl/entry_bus_seq_dp.sv
module entry_bus_seq_dp
  import entry_bus_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strb,
  input  logic [BUS_W-1:0]   dinData,
  input  logic [ENTRY_W-1:0] rdEntry,
  output logic [ENTRY_W-1:0] entryOut,
  output logic [BUS_W-1:0]   doutData,
  output logic               doutValid
);

  localparam logic [ENTRY_W-1:0] WIDE_MASK   = {{(ENTRY_W-BUS_W){1'b0}}, {BUS_W{1'b1}}};
  localparam logic [ENTRY_W-1:0] NARROW_MASK = {{(ENTRY_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [BUS_W-1:0]   OUT_NARROW  = {{(BUS_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [ENTRY_W-1:0] sliceMask;
  logic [ENTRY_W-1:0] dinShifted;
  logic [BUS_W-1:0]   doutNext;

  always_comb begin
    sliceMask  = (strb.wide ? WIDE_MASK : NARROW_MASK) << strb.lo;
    dinShifted = ENTRY_W'(dinData) << strb.lo;
    doutNext   = BUS_W'(rdEntry >> strb.lo) & (strb.wide ? {BUS_W{1'b1}} : OUT_NARROW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entryOut  <= '0;
      doutData  <= '0;
      doutValid <= 1'b0;
    end else begin
      if (strb.load) begin
        entryOut <= (entryOut & ~sliceMask) | (dinShifted & sliceMask);
      end
      doutValid <= strb.emit;
      if (strb.emit) begin
        doutData <= doutNext;
      end
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strb.emit && !strb.wide) |=> (doutValid && (doutData[BUS_W-1:HALF_W] == '0))); // R5

  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(entryOut)); // R10

endmodule

// File: rtl/entry_bus_seq.sv
module entry_bus_seq
  import entry_bus_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgLoad,
  input  logic               cfgWideIn,
  input  logic [1:0]         cfgPartIn,
  input  logic               opValid,
  input  logic [2:0]         opCode,
  input  logic               dinWrite,
  input  logic [BUS_W-1:0]   dinData,
  input  logic [ENTRY_W-1:0] rdEntry,
  output logic [ENTRY_W-1:0] entryOut,
  output logic [BUS_W-1:0]   doutData,
  output logic               doutValid,
  output logic               done,
  output logic               busy
);

  strobe_t strb;

  entry_bus_seq_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfgLoad   (cfgLoad),
    .cfgWideIn (cfgWideIn),
    .cfgPartIn (cfgPartIn),
    .opValid   (opValid),
    .opCode    (opCode),
    .dinWrite  (dinWrite),
    .strb      (strb),
    .done      (done),
    .busy      (busy)
  );

  entry_bus_seq_dp i_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .dinData   (dinData),
    .rdEntry   (rdEntry),
    .entryOut  (entryOut),
    .doutData  (doutData),
    .doutValid (doutValid)
  );

  AST_VALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    doutValid |-> ($past(busy))); // R8

endmodule

// File: tb/test_entry_bus_seq.sv
module test_entry_bus_seq;
  import entry_bus_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgLoad = 1'b0;
  logic        cfgWideIn = 1'b1;
  logic [1:0]  cfgPartIn = 2'd0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd7;
  logic        dinWrite = 1'b0;
  logic [31:0] dinData = '0;
  logic [79:0] rdEntry = '0;
  logic [79:0] entryOut;
  logic [31:0] doutData;
  logic        doutValid;
  logic        done;
  logic        busy;

  always #2 clk = ~clk;

  entry_bus_seq i_entry_bus_seq (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgWideIn(cfgWideIn),
    .cfgPartIn(cfgPartIn), .opValid(opValid), .opCode(opCode),
    .dinWrite(dinWrite), .dinData(dinData), .rdEntry(rdEntry),
    .entryOut(entryOut), .doutData(doutData), .doutValid(doutValid),
    .done(done), .busy(busy)
  );

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [31:0] data; int at; } expWord_t;
  expWord_t doutQ[$];
  int       doneQ[$];
  expWord_t mE;
  int       mDone;

  // Bench model of the configuration and entry register
  bit          mWide = 1'b1;
  logic [1:0]  mPart = 2'd0;
  logic [79:0] mEntry = '0;
  int          sLo[5];
  int          sWid[5];
  bit          sRam[5];
  int          sN;

  task automatic check(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putSlice(input int i, input int lo, input int wid, input bit ram);
    sLo[i] = lo; sWid[i] = wid; sRam[i] = ram;
  endtask

  // Slice list per configuration, written out from the requirement tables
  task automatic buildSlices();
    int camW;
    camW = 80 - 16 * int'(mPart);
    if (!mWide) begin
      for (int i = 0; i < 5; i++) putSlice(i, 16 * i, 16, (16 * i) >= camW);
      sN = 5;
    end else begin
      sN = 3;
      case (mPart)
        2'd0: begin putSlice(0, 0, 32, 0); putSlice(1, 32, 32, 0); putSlice(2, 64, 16, 0); end
        2'd1: begin putSlice(0, 0, 32, 0); putSlice(1, 32, 32, 0); putSlice(2, 64, 16, 1); end
        2'd2: begin putSlice(0, 0, 32, 0); putSlice(1, 32, 16, 0); putSlice(2, 48, 32, 1); end
        default: begin putSlice(0, 0, 32, 0); putSlice(1, 32, 32, 1); putSlice(2, 64, 16, 1); end
      endcase
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (doutValid) begin
        if (doutQ.size() == 0) begin
          check(1'b0, "R7 unexpected output word", 80'(doutData), 80'(0));
        end else begin
          mE = doutQ.pop_front();
          check(doutData == mE.data, "R7 output word value", 80'(doutData), 80'(mE.data));
          check(cyc == mE.at, "R8 output word cycle", 80'(cyc), 80'(mE.at));
        end
      end
      if (done) begin
        if (doneQ.size() == 0) begin
          check(1'b0, "R9 unexpected done", 80'(cyc), 80'(0));
        end else begin
          mDone = doneQ.pop_front();
          check(cyc == mDone, "R9 done cycle", 80'(cyc), 80'(mDone));
        end
      end
    end
  end

  task automatic setCfg(input bit wide, input logic [1:0] part);
    @(negedge clk);
    cfgLoad = 1'b1; cfgWideIn = wide; cfgPartIn = part;
    @(negedge clk);
    cfgLoad = 1'b0;
    mWide = wide; mPart = part;
  endtask

  // Driver: issues one operation and pushes its expected results
  task automatic runOp(input logic [2:0] op, input logic [79:0] wrVal,
                       input logic [79:0] rdVal, input int gap, input bit interfere);
    bit wCam, wRam, rCam, rRam;
    int wIdx[$];
    int rIdx[$];
    int t0, base, target;
    expWord_t e;
    wCam = (op <= 3'd4);
    wRam = (op == 3'd0) || (op == 3'd3);
    rRam = (op == 3'd1) || (op == 3'd2) || (op == 3'd5) || (op == 3'd6);
    rCam = (op == 3'd5) || (op == 3'd6);
    buildSlices();
    for (int i = 0; i < sN; i++) begin
      if (sRam[i] ? wRam : wCam) wIdx.push_back(i);
      if (sRam[i] ? rRam : rCam) rIdx.push_back(i);
    end
    @(negedge clk);
    t0 = cyc;
    opValid = 1'b1; opCode = op; rdEntry = rdVal;
    base = (wIdx.size() > 0) ? 1 + (wIdx.size() - 1) * (1 + gap) : 0;
    for (int i = 0; i < rIdx.size(); i++) begin
      e.data = 32'(rdVal >> sLo[rIdx[i]]);
      if (sWid[rIdx[i]] == 16) e.data[31:16] = '0;
      e.at = t0 + base + 2 + i;
      doutQ.push_back(e);
    end
    target = t0 + base + rIdx.size() + 1;
    doneQ.push_back(target);
    for (int i = 0; i < wIdx.size(); i++) begin
      @(negedge clk);
      opValid = 1'b0;
      cfgLoad = 1'b0;
      if (interfere && i == 0) begin
        opValid = 1'b1; opCode = 3'd5;              // R10 opcode while busy
        cfgLoad = 1'b1; cfgWideIn = !mWide;         // R2 load while busy
        cfgPartIn = mPart + 2'd1;
      end
      dinWrite = 1'b1;
      dinData = 32'(wrVal >> sLo[wIdx[i]]);
      if (sWid[wIdx[i]] == 16) dinData[31:16] = 16'hA5C3 ^ 16'(i); // R5 junk upper half
      for (int b = 0; b < sWid[wIdx[i]]; b++) mEntry[sLo[wIdx[i]] + b] = wrVal[sLo[wIdx[i]] + b];
      if (i < wIdx.size() - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          dinWrite = 1'b0; opValid = 1'b0; cfgLoad = 1'b0;
          dinData = 32'hFFFF_FFFF;
        end
      end
    end
    @(negedge clk);
    opValid = 1'b0; dinWrite = 1'b0; cfgLoad = 1'b0;
    while (cyc < target) @(negedge clk);
    check(entryOut == mEntry, "R6 assembled entry", entryOut, mEntry);
  endtask

  always @(posedge clk) begin
    if (cyc > 5000) begin
      nChecks++; nFail++;
      $display("FAIL R8 watchdog actual=%0d expected<5000", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !doutValid, "R1 reset flags",
          80'({busy, done, doutValid}), 80'(0));
    check(entryOut == '0, "R1 reset entry", entryOut, 80'(0));
    check(doutData == '0, "R1 reset dout", 80'(doutData), 80'(0));

    // R3 default 32-bit, no RAM: insert then search with empty RAM read (R9)
    runOp(3'd0, 80'h1234_5678_9ABC_DEF0_1357, '0, 0, 1'b0);
    runOp(3'd1, 80'hCAFE_F00D_0BAD_BEEF_4242, 80'hFFFF_EEEE_DDDD_CCCC_BBBB, 0, 1'b0);

    // R3 partition 2, learn with gaps, narrow CAM remainder (R5)
    setCfg(1'b1, 2'd2);
    runOp(3'd3, 80'h0F1E_2D3C_4B5A_6978_8796, '0, 1, 1'b0);
    runOp(3'd2, 80'h1111_2222_3333_4444_5555, 80'hABCD_EF01_2345_6789_9876, 0, 1'b0);

    // R7 queue read, partition 3
    setCfg(1'b1, 2'd3);
    runOp(3'd5, '0, 80'h9988_7766_5544_3322_1100, 0, 1'b0);

    // R2 and R10: opcode and config load while busy are ignored
    setCfg(1'b1, 2'd1);
    runOp(3'd4, 80'h7777_6666_5555_4444_3333, '0, 0, 1'b1);
    runOp(3'd6, '0, 80'h0102_0304_0506_0708_090A, 0, 1'b0);

    // R4 16-bit bus
    setCfg(1'b0, 2'd1);
    runOp(3'd0, 80'hFEDC_BA98_7654_3210_0F0F, '0, 0, 1'b0);
    setCfg(1'b0, 2'd3);
    runOp(3'd6, '0, 80'h1357_9BDF_2468_ACE0_5A5A, 0, 1'b0);
    setCfg(1'b0, 2'd2);
    runOp(3'd1, 80'h4444_3333_2222_1111_0000, 80'hAAAA_BBBB_CCCC_DDDD_EEEE, 2, 1'b0);
    setCfg(1'b0, 2'd0);
    runOp(3'd1, 80'h0A0B_0C0D_0E0F_1011_1213, 80'h1, 0, 1'b0);

    // R9 opcode with nothing to transfer
    runOp(3'd7, '0, '0, 0, 1'b0);

    // R10 write strobe while idle has no effect
    @(negedge clk);
    dinWrite = 1'b1; dinData = 32'hDEAD_BEEF;
    @(negedge clk);
    dinWrite = 1'b0;
    @(negedge clk);
    check(entryOut == mEntry, "R10 idle write ignored", entryOut, mEntry);

    repeat (4) @(negedge clk);
    check(doutQ.size() == 0, "R8 pending output words", 80'(doutQ.size()), 80'(0));
    check(doneQ.size() == 0, "R9 pending done pulses", 80'(doneQ.size()), 80'(0));
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule